// File: doc/BRIEF.md
# Strobed-Address One-of-Sixteen Decoder

This block turns a 4-bit address into a one-hot selection over sixteen outputs. The address does not feed the decoder directly. It passes through a holding register that a strobe controls. While the strobe is high, the register loads the address on every clock. While the strobe is low, the register keeps its contents, so later address changes have no effect.

An active-low enable gates the selection after the holding register. The enable is never captured by the strobe. This lets the block serve as a one-to-sixteen demultiplexer: the enable carries the data and the held address steers it to one output. It can also serve as a chip select when several decoders are cascaded. A build-time parameter sets whether an asserted output is driven high or low.

The whole block is synchronous. The outputs come from a register that reflects the held address and the enable as they stood at the previous clock edge.

Top module: `strobe_select_decoder`

## Requirements
- R1: With `latchStrobe` high at a rising edge, the held address takes the value of `addrIn`. The new selection appears at `selOut` after the following rising edge.
- R2: With `latchStrobe` low at a rising edge, the held address keeps its value. Changes on `addrIn` while the strobe stays low have no effect on `selOut`.
- R3: If `enableN` was 0 at the previous rising edge, exactly one output is active. It is `selOut[k]`, where k is the held address read as an unsigned number with `addrIn[3]` as the most significant bit.
- R4: If `enableN` was 1 at the previous rising edge, every bit of `selOut` is inactive, whatever the address and strobe are.
- R5: With `ActiveLow` = 0 (the default), active means 1 and inactive means 0. With `ActiveLow` = 1, active means 0 and inactive means 1.
- R6: The holding register does not hold `enableN`. A change of the enable reaches `selOut` after one rising edge, even while the strobe is low.
- R7: A synchronous `rst` clears the held address to 0 and drives every output to its inactive level. After `rst` is released, with `enableN` low and the strobe low, `selOut[0]` becomes active after one edge.
- R8: When the strobe falls, the address sampled at the last edge with the strobe high is kept. Addresses presented from then on are ignored until the strobe rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addrIn | input | AddrW (4) | Address to decode, bit 3 most significant |
| latchStrobe | input | 1 | High: the holding register loads the address; low: it holds |
| enableN | input | 1 | Active-low output enable, also the demultiplexer data input |
| selOut | output | 2**AddrW (16) | Registered one-hot selection, polarity set by ActiveLow |

## Verification
The bench runs a copy of the decoder in each polarity side by side. It sweeps all sixteen addresses with the strobe open, then keeps the strobe closed while the address and enable change. A decoder that let the address through a closed strobe would move its selection away from the held index. One that held the enable in the register would lag or freeze the enable while the strobe is low. The bench also checks the boundary at the strobe's falling edge: a design that captured one edge late or early would keep the wrong address. It also checks the reset release, where output 0 must be the first one selected. Swapping the polarity, or reversing the bit order of the address, shows up as a mismatch in one of the two copies.

// File: rtl/strobe_dec_pkg.sv
package strobe_dec_pkg;

  // Strobes sent from the control module to the datapath
  typedef struct packed {
    logic loadAddr;   // holding register takes the address this edge
    logic clearAll;   // synchronous clear of all state
    logic driveOut;   // output register follows the decode this edge
  } dec_ctl_t;

endpackage

// File: rtl/strobe_dec_ctrl.sv
module strobe_dec_ctrl
  import strobe_dec_pkg::*;
(
  input  logic     rst,
  input  logic     latchStrobe,
  output dec_ctl_t ctl
);

  always_comb begin
    ctl          = '0;
    ctl.clearAll = rst;
    ctl.loadAddr = latchStrobe && !rst;
    ctl.driveOut = !rst;
  end

endmodule

// File: rtl/strobe_dec_path.sv
module strobe_dec_path
  import strobe_dec_pkg::*;
#(
  parameter int AddrW     = 4,
  parameter bit ActiveLow = 1'b0
) (
  input  logic                 clk,
  input  dec_ctl_t             ctl,
  input  logic [AddrW-1:0]     addrIn,
  input  logic                 enableN,
  output logic [(1<<AddrW)-1:0] selOut
);

  localparam int OutN = 1 << AddrW;
  localparam logic [OutN-1:0] IdleVec = ActiveLow ? {OutN{1'b1}} : {OutN{1'b0}};

  logic [AddrW-1:0] heldAddr;
  logic [OutN-1:0]  hitVec;
  logic [OutN-1:0]  nextOut;
  logic [OutN-1:0]  selReg;
  logic [OutN-1:0]  actVec;

  // Strobed holding stage for the address only
  always_ff @(posedge clk) begin
    if (ctl.clearAll) begin
      heldAddr <= '0;
    end else if (ctl.loadAddr) begin
      heldAddr <= addrIn;
    end
  end

  // One comparator per output; the enable gates after the holding stage
  for (genvar i = 0; i < OutN; i++) begin : gen_decode
    assign hitVec[i] = !enableN && (heldAddr == AddrW'(i));
  end

  // Polarity chosen at build time
  if (ActiveLow) begin : gen_pol_low
    assign nextOut = ~hitVec;
    assign actVec  = ~selReg;
  end else begin : gen_pol_high
    assign nextOut = hitVec;
    assign actVec  = selReg;
  end

  always_ff @(posedge clk) begin
    if (ctl.clearAll) begin
      selReg <= IdleVec;
    end else if (ctl.driveOut) begin
      selReg <= nextOut;
    end
  end

  assign selOut = selReg;

  // R2: a closed strobe freezes the held address
  assert_hold_R2: assert property (@(posedge clk) disable iff (ctl.clearAll)
    !ctl.loadAddr |=> $stable(heldAddr));

  // R3: enabled means exactly one active output
  assert_onehot_R3: assert property (@(posedge clk) disable iff (ctl.clearAll)
    (!$past(ctl.clearAll) && !$past(enableN)) |-> ($countones(actVec) == 1));

  // R3: the active output index is the held address
  assert_index_R3: assert property (@(posedge clk) disable iff (ctl.clearAll)
    (!$past(ctl.clearAll) && !$past(enableN)) |-> actVec[$past(heldAddr)]);

  // R4: disabled means nothing active
  assert_idle_R4: assert property (@(posedge clk) disable iff (ctl.clearAll)
    (!$past(ctl.clearAll) && $past(enableN)) |-> (actVec == '0));

  // R1: an open strobe loads the presented address
  assert_load_R1: assert property (@(posedge clk) disable iff (ctl.clearAll)
    ctl.loadAddr |=> (heldAddr == $past(addrIn)));

endmodule

// File: rtl/strobe_select_decoder.sv
module strobe_select_decoder
  import strobe_dec_pkg::*;
#(
  parameter int AddrW     = 4,
  parameter bit ActiveLow = 1'b0,
  localparam int OutN     = 1 << AddrW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AddrW-1:0] addrIn,
  input  logic             latchStrobe,
  input  logic             enableN,
  output logic [OutN-1:0]  selOut
);

  dec_ctl_t ctl;

  strobe_dec_ctrl ctrl_i (
    .rst        (rst),
    .latchStrobe(latchStrobe),
    .ctl        (ctl)
  );

  strobe_dec_path #(
    .AddrW    (AddrW),
    .ActiveLow(ActiveLow)
  ) path_i (
    .clk    (clk),
    .ctl    (ctl),
    .addrIn (addrIn),
    .enableN(enableN),
    .selOut (selOut)
  );

endmodule

// File: tb/strobe_select_decoder_tb.sv
module strobe_select_decoder_tb_top;

  localparam int AddrW = 4;
  localparam int OutN  = 1 << AddrW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AddrW-1:0] addrIn = '0;
  logic latchStrobe = 1'b0;
  logic enableN = 1'b1;
  logic [OutN-1:0] selHi;
  logic [OutN-1:0] selLo;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state
  logic [AddrW-1:0] mAddr = '0;
  logic [OutN-1:0]  mAct  = '0;

  always #4 clk = ~clk;  // 125 MHz

  strobe_select_decoder #(.AddrW(AddrW), .ActiveLow(1'b0)) dut_i (
    .clk(clk), .rst(rst), .addrIn(addrIn), .latchStrobe(latchStrobe),
    .enableN(enableN), .selOut(selHi));

  strobe_select_decoder #(.AddrW(AddrW), .ActiveLow(1'b1)) dutLow_i (
    .clk(clk), .rst(rst), .addrIn(addrIn), .latchStrobe(latchStrobe),
    .enableN(enableN), .selOut(selLo));

  task automatic compare(input string tag);
    checks++;
    if (selHi !== mAct) begin
      errors++;
      $display("FAIL %s high-polarity: actual %h expected %h", tag, selHi, mAct);
    end
    checks++;
    if (selLo !== ~mAct) begin
      errors++;
      $display("FAIL %s R5 low-polarity: actual %h expected %h", tag, selLo, ~mAct);
    end
  endtask

  // Called at a falling edge: drive, cross one rising edge, compare at next falling edge
  task automatic step(input logic s, input logic [AddrW-1:0] a, input logic e,
                      input string tag);
    latchStrobe = s;
    addrIn      = a;
    enableN     = e;
    @(posedge clk);
    if (rst) begin
      mAct  = '0;
      mAddr = '0;
    end else begin
      mAct = e ? '0 : (OutN'(1) << mAddr);
      if (s) mAddr = a;
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    logic [7:0] lfsr;
    lfsr = 8'hA5;
    rst = 1'b1;
    // reset state, with the strobe open and the enable low
    @(negedge clk);
    step(1'b1, 4'd9, 1'b0, "R7 reset");
    step(1'b1, 4'd6, 1'b0, "R7 reset");
    rst = 1'b0;
    // first edge after release: held address is 0
    step(1'b0, 4'd11, 1'b0, "R7 release");
    step(1'b0, 4'd11, 1'b0, "R7 hold zero");

    // R1/R3: sweep all addresses with the strobe open
    for (int i = 0; i < OutN; i++) step(1'b1, AddrW'(i), 1'b0, "R1 R3 sweep");
    step(1'b0, 4'd0, 1'b0, "R3 last");

    // R8: capture at strobe fall, then R2: addresses ignored
    step(1'b1, 4'd13, 1'b0, "R8 open");
    step(1'b0, 4'd2, 1'b0, "R8 capture");
    for (int i = 0; i < OutN; i++) step(1'b0, AddrW'(i), 1'b0, "R2 ignore");

    // R4/R6: enable toggles while the strobe is closed
    for (int i = 0; i < 8; i++) step(1'b0, AddrW'(15 - i), i[0], "R4 R6 toggle");
    for (int i = 0; i < OutN; i++) step(1'b1, AddrW'(i), 1'b1, "R4 disabled load");
    step(1'b0, 4'd3, 1'b0, "R6 reenable");

    // demultiplexing pattern: enable as data, strobe both ways
    for (int i = 0; i < 200; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr[7], lfsr[3:0], lfsr[5], "R1 R2 R3 R4 mixed");
    end

    // reset mid-run, then release
    rst = 1'b1;
    step(1'b1, 4'd7, 1'b0, "R7 second reset");
    rst = 1'b0;
    step(1'b0, 4'd7, 1'b0, "R7 second release");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule